// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between the receive shift register of a 16550-style serial channel and the host. Each time the shift register finishes a character, it hands over eight data bits together with a parity-error flag and a stop-bit error flag. The block keeps the character in one of two ways, chosen by `fifoEn`. In single mode it holds one character in a holding register. In queue mode it holds up to sixteen characters in a first-in, first-out store. The error flags are stored in the same entry as the character they belong to.

The host reads the head character through a one-cycle data-read strobe. It reads the status through a one-cycle status-read strobe. The status outputs are:
- data ready;
- overrun;
- parity error;
- framing error, meaning the bit after the last data or parity bit was sampled as 0.

The three error bits stay set until the host reads the status. Any one of them raises the receiver line-status interrupt request, which is the highest-priority receive interrupt. A test-only write strobe can load the three error bits directly. Software should treat the status as read-only.

Top module: `rx_line_queue`

## Requirements
- R1: `dataReady` is 1 whenever at least one character is held. A data read that removes the last character drops it to 0 on the next cycle. A data read while nothing is held changes no output.
- R2: In single mode (`fifoEn`=0), a character that arrives while the holding register is occupied, with no data read in the same cycle, replaces the held character and sets `overrun`.
- R3: In queue mode (`fifoEn`=1), the store holds 16 characters. A character that arrives while 16 are held, with no data read in the same cycle, is discarded, the 16 stored characters are kept unchanged, and `overrun` is set.
- R4: A status read (`rdStatus`) clears `overrun`, `parErr` and `frmErr` on the next cycle, unless a new event sets them in that same cycle.
- R5: When an error event and a status read happen in the same cycle, the error bit is set afterwards.
- R6: `parErr` and `frmErr` take the flags of the character at the head of the store. They set when a flagged character becomes the head. A flagged character waiting behind the head does not set them.
- R7: `lineIrq` is 1 exactly when at least one of `overrun`, `parErr` or `frmErr` is 1.
- R8: Characters are read out on `rdByte` in the order they arrived. `rdByte` shows the head character while `dataReady` is 1.
- R9: A test write (`wrStatus`) loads `overrun`, `parErr` and `frmErr` from `wrValue[1]`, `wrValue[2]` and `wrValue[3]`. It leaves `dataReady` unchanged.
- R10: When `fifoEn` changes value, the store is emptied and `dataReady` is 0 on the next cycle.
- R11: A character that arrives in the same cycle as a data read of a full store is stored and does not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1 = 16-entry queue mode, 0 = single holding register |
| rxValid | input | 1 | A received character is complete this cycle |
| rxData | input | 8 | Received character |
| rxParErr | input | 1 | Received character has a parity error |
| rxFrmErr | input | 1 | Received character had a 0 where the stop bit belongs |
| rdData | input | 1 | Host reads the data register (removes the head) |
| rdStatus | input | 1 | Host reads the status register |
| wrStatus | input | 1 | Test-only write of the status register |
| wrValue | input | 8 | Test write value (bits 1, 2, 3 used) |
| rdByte | output | 8 | Head character |
| dataReady | output | 1 | At least one character held |
| overrun | output | 1 | A character was lost or overwritten |
| parErr | output | 1 | Head character had a parity error |
| frmErr | output | 1 | Head character had a stop-bit error |
| lineIrq | output | 1 | Receiver line-status interrupt request |

## Verification
The bench places flagged characters behind a clean head. A design that reported the newest character's flags, rather than the head's, would raise `parErr` too early. It fills the queue to sixteen and sends one more character. A design that wrote past capacity would corrupt the first entry or return seventeen characters. It also sends a character in the same cycle as a data read of a full queue, where an off-by-one full test would wrongly flag `overrun` or drop the character. A status read in the same cycle as a flagged arrival checks that clear-on-read does not swallow the new error. A mode change checks that the stale contents are flushed.

// File: rtl/rx_line_queue_pkg.sv
package rx_line_queue_pkg;
  localparam int QDEPTH = 16;
  localparam int DWIDTH = 8;
  localparam int AW = $clog2(QDEPTH);
  localparam int CW = AW + 1;

  typedef struct packed {
    logic frmErr;
    logic parErr;
    logic [DWIDTH-1:0] data;
  } entry_t;

  typedef struct packed {
    logic wrEn;
    logic [AW-1:0] wrAddr;
    logic [AW-1:0] rdAddr;
    logic [AW-1:0] headAddr;
    logic headLoad;
    logic headFromIn;
  } strobe_t;
endpackage

// File: rtl/rx_line_queue_ctrl.sv
module rx_line_queue_ctrl
  import rx_line_queue_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic fifoEn,
  input  logic rxValid,
  input  logic rdData,
  input  logic rdStatus,
  input  logic wrStatus,
  input  logic wrOverrun,
  output strobe_t st,
  output logic dataReady,
  output logic overrun
);
  localparam logic [CW-1:0] FULL_CNT = CW'(QDEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(QDEPTH - 1);

  logic [AW-1:0] wrPtr, rdPtr, rdNext, wrNext;
  logic [CW-1:0] count;
  logic prevMode, flush, full, pop, accept, overwrite, ovrEvent, headFromIn;

  assign rdNext = (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
  assign wrNext = (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
  assign flush = (fifoEn != prevMode);
  assign full = fifoEn ? (count == FULL_CNT) : (count != '0);
  assign pop = rdData && (count != '0) && !flush;
  assign accept = rxValid && !flush && (!full || pop);
  assign overwrite = rxValid && !flush && full && !pop && !fifoEn;
  assign ovrEvent = rxValid && !flush && full && !pop;
  assign headFromIn = overwrite ||
                      (accept && ((count == '0) || (pop && count == CW'(1))));

  always_comb begin
    st.wrEn = accept || overwrite;
    st.wrAddr = overwrite ? rdPtr : wrPtr;
    st.rdAddr = rdPtr;
    st.headAddr = rdNext;
    st.headFromIn = headFromIn;
    st.headLoad = headFromIn || (pop && count > CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      prevMode <= 1'b0;
    end else begin
      prevMode <= fifoEn;
      if (flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (accept) wrPtr <= wrNext;
        if (pop) rdPtr <= rdNext;
        case ({accept, pop})
          2'b10: count <= count + 1'b1;
          2'b01: count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overrun <= 1'b0;
    else if (wrStatus) overrun <= wrOverrun | ovrEvent;
    else overrun <= (overrun & ~rdStatus) | ovrEvent;
  end

  assign dataReady = (count != '0);

  AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && rdData && !rxValid) |=> (count == '0)); // R1
  AST_SINGLE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && count <= CW'(1)) |=> (count <= CW'(1))); // R2
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && !flush && count == FULL_CNT && rxValid && !rdData)
    |=> (overrun && $stable(wrPtr) && count == FULL_CNT)); // R3
  AST_OVR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !wrStatus && !ovrEvent) |=> !overrun); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0)); // R10
endmodule

// File: rtl/rx_line_queue_dp.sv
module rx_line_queue_dp
  import rx_line_queue_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobe_t st,
  input  logic [DWIDTH-1:0] rxData,
  input  logic rxParErr,
  input  logic rxFrmErr,
  input  logic rdStatus,
  input  logic wrStatus,
  input  logic wrPar,
  input  logic wrFrm,
  output logic [DWIDTH-1:0] rdByte,
  output logic parErr,
  output logic frmErr
);
  entry_t mem [QDEPTH];
  entry_t inEntry;
  logic newPe, newFe, peEvent, feEvent, peBase, feBase;

  assign inEntry = '{frmErr: rxFrmErr, parErr: rxParErr, data: rxData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) mem[i] <= '0;
    end else if (st.wrEn) begin
      mem[st.wrAddr] <= inEntry;
    end
  end

  assign rdByte = mem[st.rdAddr].data;
  assign newPe = st.headFromIn ? rxParErr : mem[st.headAddr].parErr;
  assign newFe = st.headFromIn ? rxFrmErr : mem[st.headAddr].frmErr;
  assign peEvent = st.headLoad && newPe;
  assign feEvent = st.headLoad && newFe;
  assign peBase = wrStatus ? wrPar : (parErr & ~rdStatus);
  assign feBase = wrStatus ? wrFrm : (frmErr & ~rdStatus);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parErr <= 1'b0;
      frmErr <= 1'b0;
    end else begin
      parErr <= peBase | peEvent;
      frmErr <= feBase | feEvent;
    end
  end

  AST_PE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !wrStatus && !st.headLoad) |=> !parErr); // R4
  AST_FE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !wrStatus && !st.headLoad) |=> !frmErr); // R4
  AST_NEW_HEAD_PE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (st.headLoad && st.headFromIn && rxParErr) |=> parErr); // R5
  AST_NO_HEAD_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!st.headLoad && !wrStatus && !parErr) |=> !parErr); // R6
endmodule

// File: rtl/rx_line_queue.sv
module rx_line_queue
  import rx_line_queue_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic fifoEn,
  input  logic rxValid,
  input  logic [7:0] rxData,
  input  logic rxParErr,
  input  logic rxFrmErr,
  input  logic rdData,
  input  logic rdStatus,
  input  logic wrStatus,
  input  logic [7:0] wrValue,
  output logic [7:0] rdByte,
  output logic dataReady,
  output logic overrun,
  output logic parErr,
  output logic frmErr,
  output logic lineIrq
);
  strobe_t st;

  rx_line_queue_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxValid(rxValid),
    .rdData(rdData), .rdStatus(rdStatus), .wrStatus(wrStatus),
    .wrOverrun(wrValue[1]), .st(st), .dataReady(dataReady), .overrun(overrun)
  );

  rx_line_queue_dp uDp (
    .clk(clk), .rstN(rstN), .st(st), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rdStatus(rdStatus), .wrStatus(wrStatus),
    .wrPar(wrValue[2]), .wrFrm(wrValue[3]), .rdByte(rdByte),
    .parErr(parErr), .frmErr(frmErr)
  );

  assign lineIrq = overrun | parErr | frmErr;

  AST_IRQ_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !wrStatus && !rxValid && !rdData) |=> !lineIrq); // R7
endmodule

// File: tb/rx_line_queue_test.sv
module rx_line_queue_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b0, rxValid = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0;
  logic rdData = 1'b0, rdStatus = 1'b0, wrStatus = 1'b0;
  logic [7:0] rxData = '0, wrValue = '0;
  logic [7:0] rdByte;
  logic dataReady, overrun, parErr, frmErr, lineIrq;
  int nTests = 0, nFail = 0;

  always #5 clk = ~clk;

  rx_line_queue uut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxValid(rxValid), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rdData(rdData), .rdStatus(rdStatus),
    .wrStatus(wrStatus), .wrValue(wrValue), .rdByte(rdByte), .dataReady(dataReady),
    .overrun(overrun), .parErr(parErr), .frmErr(frmErr), .lineIrq(lineIrq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    rxValid = 0; rdData = 0; rdStatus = 0; wrStatus = 0;
    rxParErr = 0; rxFrmErr = 0;
  endtask

  task automatic push(logic [7:0] d, logic pe, logic fe);
    rxData = d; rxParErr = pe; rxFrmErr = fe; rxValid = 1; tick();
  endtask

  task automatic pull(logic [7:0] exp, string tag);
    check(tag, rdByte, exp); rdData = 1; tick();
  endtask

  task automatic readStatus();
    rdStatus = 1; tick();
  endtask

  task automatic testReset();
    check("R1 reset dataReady", dataReady, 0);
    check("R7 reset lineIrq", lineIrq, 0);
    check("R4 reset errors", {overrun, parErr, frmErr}, 0);
  endtask

  task automatic testSingleBasic();
    push(8'h41, 0, 0);
    check("R1 ready after arrival", dataReady, 1);
    pull(8'h41, "R8 single data");
    check("R1 ready cleared", dataReady, 0);
    rdData = 1; tick();
    check("R1 empty read no effect", {dataReady, overrun, lineIrq}, 0);
  endtask

  task automatic testSingleOverrun();
    push(8'h10, 0, 0);
    push(8'h20, 0, 0);
    check("R2 overrun set", overrun, 1);
    check("R7 irq from overrun", lineIrq, 1);
    pull(8'h20, "R2 overwritten data");
    check("R2 holding empties", dataReady, 0);
    readStatus();
    check("R4 overrun cleared", overrun, 0);
    check("R7 irq cleared", lineIrq, 0);
  endtask

  task automatic testQueueFull();
    fifoEn = 1; tick();
    for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i), 0, 0);
    check("R3 no overrun at 16", overrun, 0);
    push(8'h55, 0, 0);
    check("R3 overrun on 17th", overrun, 1);
    for (int i = 0; i < 16; i++) pull(8'hA0 + 8'(i), "R8 R3 order kept");
    check("R3 only 16 stored", dataReady, 0);
    readStatus();
    check("R4 overrun cleared fifo", overrun, 0);
  endtask

  task automatic testHeadFlags();
    push(8'h01, 0, 0);
    push(8'h02, 1, 0);
    push(8'h03, 0, 1);
    check("R6 waiting flags hidden", {parErr, frmErr}, 0);
    pull(8'h01, "R8 head 1");
    check("R6 pe at head", {parErr, frmErr}, 2'b10);
    check("R7 irq from pe", lineIrq, 1);
    readStatus();
    check("R4 pe cleared", parErr, 0);
    pull(8'h02, "R8 head 2");
    check("R6 fe at head", {parErr, frmErr}, 2'b01);
    readStatus();
    check("R4 fe cleared", frmErr, 0);
    pull(8'h03, "R8 head 3");
  endtask

  task automatic testReadCollision();
    rxData = 8'h66; rxParErr = 1; rxValid = 1; rdStatus = 1; tick();
    check("R5 new error survives read", parErr, 1);
    readStatus();
    check("R4 pe cleared later", parErr, 0);
    pull(8'h66, "R8 collision data");
  endtask

  task automatic testFullReadWrite();
    for (int i = 0; i < 16; i++) push(8'hB0 + 8'(i), 0, 0);
    check("R11 head before", rdByte, 8'hB0);
    rxData = 8'h77; rxValid = 1; rdData = 1; tick();
    check("R11 no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) pull(8'hB0 + 8'(i), "R11 R8 remaining");
    pull(8'h77, "R11 late char stored");
    check("R11 empty at end", dataReady, 0);
  endtask

  task automatic testWriteStatus();
    wrValue = 8'h0E; wrStatus = 1; tick();
    check("R9 test write loads", {overrun, parErr, frmErr}, 3'b111);
    check("R9 ready untouched", dataReady, 0);
    readStatus();
    check("R4 test bits cleared", {overrun, parErr, frmErr, lineIrq}, 0);
  endtask

  task automatic testModeFlush();
    push(8'h31, 0, 0);
    push(8'h32, 0, 0);
    check("R10 ready before switch", dataReady, 1);
    fifoEn = 0; tick();
    check("R10 flushed", dataReady, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testSingleBasic();
    testSingleOverrun();
    testQueueFull();
    testHeadFlags();
    testReadCollision();
    testFullReadWrite();
    testWriteStatus();
    fifoEn = 1; tick();
    testModeFlush();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #200000;
    nTests++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule